// File: doc/BRIEF.md
# Receive Interrupt Delay Timer

This block paces receive interrupts on a network receive path. Each time a packet has been fully stored to host memory, a countdown restarts from a programmed delay. The countdown then runs down by one on each pulse of a slow tick strobe. If it runs out before another packet arrives, the block raises a one-cycle request to flush pending descriptor write-backs and a one-cycle receive-timer interrupt. A delay of zero turns moderation off, so every stored packet is reported at once.

A second, absolute timer bounds the total latency. It starts on the first packet that finds it idle and counts down without restarting on later packets. When it runs out it also raises the flush and interrupt pulses. It cancels the packet timer's pending expiry and leaves that timer halted until the next packet arrives. Software sets both delays through two write ports. Writing the control register with its force bit set expires the packet timer immediately. The force bit clears itself and never reads back as one.

Top module: `rx_irq_delay`

## Requirements
- R1: After reset both timers are idle. `irq_o` and `flush_o` are low. Both readback ports read zero. Ticks that come after reset and before any packet produce no pulse.
- R2: A packet loads the packet countdown with the programmed delay D (D > 0). With no further packet, the D-th tick after it makes `irq_o` and `flush_o` high together for exactly one cycle, in the cycle after that tick's edge. A packet in the same cycle as a tick reloads the countdown, and that tick is not counted.
- R3: A packet that arrives while the countdown is running reloads it to D, so the pulse follows D ticks after the latest packet.
- R4: With a programmed delay of zero, every packet produces a pulse in the cycle after the edge that samples it.
- R5: A control write with bit 16 of `cfg_wdata_i` set produces a pulse in the cycle after the write edge, whether the countdown is idle or running. It leaves the packet timer idle. The same write loads bits 15:0 as the delay.
- R6: `cfg_rdata_o` returns the stored delay in bits 15:0, and bit 16 always reads zero. `abs_rdata_o` returns the stored absolute delay.
- R7: With an absolute delay A > 0, the first packet that finds the absolute timer idle loads it with A. Packets that arrive while it runs do not restart it. Its A-th tick produces a pulse.
- R8: When the absolute timer expires, the packet timer is reloaded and halted. No pulse follows from the packet timer until a new packet arrives.
- R9: A packet that arrives after such a halt starts the packet countdown again with the full delay.
- R10: When both timers expire in the same cycle, exactly one one-cycle pulse is produced on each output.
- R11: The countdowns change only on tick cycles. A cycle without a tick leaves the remaining count unchanged.
- R12: An absolute delay of zero disables the absolute timer, so it never starts and never cancels the packet timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Time-unit strobe, one cycle per count unit |
| pkt_stored_i | input | 1 | One-cycle pulse: a packet has been stored to host memory |
| cfg_wr_i | input | 1 | Write strobe for the control register |
| cfg_wdata_i | input | 17 | Control write data: bits 15:0 delay, bit 16 force expiry |
| abs_wr_i | input | 1 | Write strobe for the absolute delay register |
| abs_wdata_i | input | 16 | Absolute delay write data |
| cfg_rdata_o | output | 17 | Control register readback (bit 16 always zero) |
| abs_rdata_o | output | 16 | Absolute delay readback |
| flush_o | output | 1 | One-cycle request to flush pending descriptor write-backs |
| irq_o | output | 1 | One-cycle receive-timer interrupt cause |

## Verification
The assertions check several rules on every cycle. A running packet countdown never holds zero. Neither countdown moves in a cycle without a tick. A running absolute timer ignores packets, and with a zero delay it never starts. An absolute expiry leaves the packet timer halted unless a packet arrives in the same cycle. A forced write is always followed by both pulses, and both outputs are low right after reset. The pulse timing can only be shown by the bench's scenarios, as can retriggering, the merging of coincident expiries into one pulse, the absence of a spurious pulse after a cancel, and the readback values.

// File: rtl/rxim_pkg.sv
// Package: shared state type for the receive interrupt delay timers.
// Assumes: both countdowns use a two-state idle/run machine.
package rxim_pkg;
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/rxim_cfg_regs.sv
// Module: rxim_cfg_regs
// Holds the packet delay and absolute delay registers. Turns a control
// write with the force bit into a single-cycle force strobe.
// Assumes: the force bit sits directly above the delay field and is never stored.
module rxim_cfg_regs #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_i,
    input  logic [DLY_W:0]   cfg_wdata_i,
    input  logic             abs_wr_i,
    input  logic [DLY_W-1:0] abs_wdata_i,
    output logic [DLY_W-1:0] pkt_dly_o,
    output logic [DLY_W-1:0] abs_dly_o,
    output logic             force_o,
    output logic [DLY_W:0]   cfg_rdata_o
);
    localparam int FORCE_BIT = DLY_W;

    logic [DLY_W-1:0] pkt_dly_q;
    logic [DLY_W-1:0] abs_dly_q;

    // Store the packet delay field on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_dly_q <= '0;
        end else if (cfg_wr_i) begin
            pkt_dly_q <= cfg_wdata_i[DLY_W-1:0];
        end
    end

    // Store the absolute delay on its own write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abs_dly_q <= '0;
        end else if (abs_wr_i) begin
            abs_dly_q <= abs_wdata_i;
        end
    end

    // The force strobe acts in the write cycle only and is not stored.
    always_comb begin
        force_o     = cfg_wr_i & cfg_wdata_i[FORCE_BIT];
        cfg_rdata_o = {1'b0, pkt_dly_q};
    end

    assign pkt_dly_o = pkt_dly_q;
    assign abs_dly_o = abs_dly_q;
endmodule

// File: rtl/rxim_pkt_timer.sv
// Module: rxim_pkt_timer
// Retriggerable packet countdown. A packet reloads it with the delay. Each
// tick decrements it. Reaching the end, a force strobe, or a packet with a
// zero delay raises fire_o. A cancel reloads it and halts it.
// Assumes: priority force > packet > cancel > expiry; a packet in a tick cycle wins.
module rxim_pkt_timer
    import rxim_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pkt_i,
    input  logic             force_i,
    input  logic             cancel_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             fire_o,
    output logic             running_o
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    tmr_state_e       state_q;
    logic [DLY_W-1:0] cnt_q;
    logic             zero_dly;
    logic             hit;

    // Decode the last tick and the immediate cases.
    always_comb begin
        zero_dly = (delay_i == '0);
        hit      = (state_q == TMR_RUN) && tick_i && (cnt_q == ONE);
        fire_o   = force_i | (pkt_i & zero_dly) | (hit & ~pkt_i);
    end

    // Countdown state: load, halt, expire or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else if (force_i) begin
            state_q <= TMR_IDLE;
            cnt_q   <= delay_i;
        end else if (pkt_i) begin
            state_q <= zero_dly ? TMR_IDLE : TMR_RUN;
            cnt_q   <= delay_i;
        end else if (cancel_i || hit) begin
            state_q <= TMR_IDLE;
            cnt_q   <= delay_i;
        end else if (state_q == TMR_RUN && tick_i) begin
            cnt_q   <= cnt_q - ONE;
        end
    end

    assign running_o = (state_q == TMR_RUN);

    // R2
    run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN) |-> (cnt_q != '0));

    // R11
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && !tick_i && !pkt_i && !force_i && !cancel_i)
        |=> (state_q == TMR_RUN) && $stable(cnt_q));
endmodule

// File: rtl/rxim_abs_timer.sv
// Module: rxim_abs_timer
// Absolute countdown. It is armed by the first packet that finds it idle and
// is not restarted by later packets. It raises fire_o on its last tick.
// Assumes: a zero delay keeps it disabled.
module rxim_abs_timer
    import rxim_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pkt_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             fire_o
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    tmr_state_e       state_q;
    logic [DLY_W-1:0] cnt_q;
    logic             arm;

    // Decode the arming and expiry conditions.
    always_comb begin
        arm    = (state_q == TMR_IDLE) && pkt_i && (delay_i != '0);
        fire_o = (state_q == TMR_RUN) && tick_i && (cnt_q == ONE);
    end

    // Countdown state: arm once, decrement on ticks, go idle at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else if (fire_o) begin
            state_q <= TMR_IDLE;
        end else if (arm) begin
            state_q <= TMR_RUN;
            cnt_q   <= delay_i;
        end else if (state_q == TMR_RUN && tick_i) begin
            cnt_q   <= cnt_q - ONE;
        end
    end

    // R7
    abs_ignore_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && pkt_i && !tick_i)
        |=> (state_q == TMR_RUN) && $stable(cnt_q));

    // R12
    abs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_IDLE && delay_i == '0) |=> (state_q == TMR_IDLE));

    // R11
    abs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rxim_irq_out.sv
// Module: rxim_irq_out
// Merges the expiry events of both timers into registered, single-cycle
// flush and interrupt pulses.
// Assumes: coincident events count as one expiry.
module rxim_irq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_fire_i,
    input  logic abs_fire_i,
    output logic flush_o,
    output logic irq_o
);
    logic any_fire;
    logic flush_q;
    logic irq_q;

    // Combine the two sources into one event.
    always_comb begin
        any_fire = pkt_fire_i | abs_fire_i;
    end

    // Register the pulses so that both outputs are glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            flush_q <= any_fire;
            irq_q   <= any_fire;
        end
    end

    assign flush_o = flush_q;
    assign irq_o   = irq_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq_q && !flush_q));
endmodule

// File: rtl/rx_irq_delay.sv
// Module: rx_irq_delay
// Top of the receive interrupt delay timer. Wires the register file, the
// packet countdown, the absolute countdown and the pulse merger.
// Assumes: tick_i and pkt_stored_i are single-cycle strobes in the clk domain.
module rx_irq_delay #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pkt_stored_i,
    input  logic             cfg_wr_i,
    input  logic [DLY_W:0]   cfg_wdata_i,
    input  logic             abs_wr_i,
    input  logic [DLY_W-1:0] abs_wdata_i,
    output logic [DLY_W:0]   cfg_rdata_o,
    output logic [DLY_W-1:0] abs_rdata_o,
    output logic             flush_o,
    output logic             irq_o
);
    localparam int FORCE_BIT = DLY_W;

    logic [DLY_W-1:0] pkt_dly;
    logic [DLY_W-1:0] abs_dly;
    logic             force_exp;
    logic             pkt_fire;
    logic             pkt_running;
    logic             abs_fire;

    rxim_cfg_regs #(.DLY_W(DLY_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .abs_wr_i    (abs_wr_i),
        .abs_wdata_i (abs_wdata_i),
        .pkt_dly_o   (pkt_dly),
        .abs_dly_o   (abs_dly),
        .force_o     (force_exp),
        .cfg_rdata_o (cfg_rdata_o)
    );

    rxim_pkt_timer #(.DLY_W(DLY_W)) u_pkt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .pkt_i     (pkt_stored_i),
        .force_i   (force_exp),
        .cancel_i  (abs_fire),
        .delay_i   (pkt_dly),
        .fire_o    (pkt_fire),
        .running_o (pkt_running)
    );

    rxim_abs_timer #(.DLY_W(DLY_W)) u_abs (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .pkt_i   (pkt_stored_i),
        .delay_i (abs_dly),
        .fire_o  (abs_fire)
    );

    rxim_irq_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_fire_i (pkt_fire),
        .abs_fire_i (abs_fire),
        .flush_o    (flush_o),
        .irq_o      (irq_o)
    );

    assign abs_rdata_o = abs_dly;

    // R8
    cancel_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abs_fire && !pkt_stored_i) |=> !pkt_running);

    // R5
    force_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && cfg_wdata_i[FORCE_BIT]) |=> (irq_o && flush_o));
endmodule

// File: tb/sim_rx_irq_delay.sv
module sim_rx_irq_delay;
    localparam int DW = 16;
    localparam int NV = 61;

    typedef struct packed {
        logic        p;
        logic        t;
        logic        c;
        logic        a;
        logic [DW:0] d;
        logic        e;
    } vec_t;

    // p=packet t=tick c=control write a=absolute write d=data e=expected pulse
    localparam vec_t VEC [NV] = '{
        '{0,1,0,0,17'h0,0},       // R11 idle tick, R1
        '{0,1,0,0,17'h0,0},       // R11
        '{1,0,0,0,17'h0,1},       // R4 zero delay immediate
        '{0,0,0,0,17'h0,0},
        '{0,0,1,0,17'h3,0},       // delay 3
        '{1,0,0,0,17'h0,0},       // R2 start
        '{0,1,0,0,17'h0,0},
        '{0,0,0,0,17'h0,0},       // R11 no tick
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,1},       // R2 expiry
        '{0,1,0,0,17'h0,0},
        '{1,0,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{1,0,0,0,17'h0,0},       // R3 retrigger
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,1},       // R3 expiry
        '{0,0,1,0,17'h10003,1},   // R5 force while idle
        '{1,0,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{0,0,1,0,17'h10003,1},   // R5 force while running
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},       // R5 timer left idle
        '{0,0,0,1,17'h5,0},       // absolute delay 5
        '{1,0,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{1,0,0,0,17'h0,0},       // R7 no restart
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{1,0,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,1},       // R7 absolute expiry
        '{0,1,0,0,17'h0,0},       // R8 no spurious pulse
        '{0,1,0,0,17'h0,0},       // R8
        '{0,1,0,0,17'h0,0},       // R8
        '{1,0,0,0,17'h0,0},       // R9 restart
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,1},       // R9 expiry
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,1},       // R7 absolute alone
        '{0,0,0,1,17'h3,0},       // absolute delay 3
        '{1,0,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,1},       // R10 coincident
        '{0,1,0,0,17'h0,0},       // R10 single pulse
        '{0,0,0,1,17'h0,0},       // absolute disabled
        '{1,0,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{1,0,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},       // R12 no absolute expiry
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,1},       // R12 packet timer expires
        '{1,0,0,0,17'h0,0},
        '{1,1,0,0,17'h0,0},       // R2 packet wins over tick
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,0},
        '{0,1,0,0,17'h0,1}        // R2 expiry after reload
    };

    logic          clk;
    logic          rst_n;
    logic          tick_i;
    logic          pkt_stored_i;
    logic          cfg_wr_i;
    logic [DW:0]   cfg_wdata_i;
    logic          abs_wr_i;
    logic [DW-1:0] abs_wdata_i;
    logic [DW:0]   cfg_rdata_o;
    logic [DW-1:0] abs_rdata_o;
    logic          flush_o;
    logic          irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    rx_irq_delay #(.DLY_W(DW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .pkt_stored_i (pkt_stored_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .abs_wr_i     (abs_wr_i),
        .abs_wdata_i  (abs_wdata_i),
        .cfg_rdata_o  (cfg_rdata_o),
        .abs_rdata_o  (abs_rdata_o),
        .flush_o      (flush_o),
        .irq_o        (irq_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tick_i       = 1'b0;
        pkt_stored_i = 1'b0;
        cfg_wr_i     = 1'b0;
        cfg_wdata_i  = '0;
        abs_wr_i     = 1'b0;
        abs_wdata_i  = '0;
    endtask

    // Drive one cycle at the falling edge; sample shortly after the rising edge.
    task automatic step(input logic p, input logic t, input logic c, input logic a,
                        input logic [DW:0] d);
        pkt_stored_i = p;
        tick_i       = t;
        cfg_wr_i     = c;
        cfg_wdata_i  = d;
        abs_wr_i     = a;
        abs_wdata_i  = d[DW-1:0];
        @(posedge clk);
        #2;
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq after reset", 32'(irq_o), 0);
        check("R1 flush after reset", 32'(flush_o), 0);
        check("R1 cfg readback", 32'(cfg_rdata_o), 0);
        check("R1 abs readback", 32'(abs_rdata_o), 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            step(VEC[i].p, VEC[i].t, VEC[i].c, VEC[i].a, VEC[i].d);
            check($sformatf("vector %0d irq", i), 32'(irq_o), 32'(VEC[i].e));
            check($sformatf("vector %0d flush", i), 32'(flush_o), 32'(VEC[i].e));
        end

        // R6 readback of stored delays, force bit never visible
        @(negedge clk);
        check("R6 cfg readback", 32'(cfg_rdata_o), 32'h3);
        check("R6 abs readback", 32'(abs_rdata_o), 32'h0);
        step(0, 0, 1, 0, 17'h1FFF7);
        check("R5 force with all ones", 32'(irq_o), 1);
        @(negedge clk);
        check("R6 force bit reads zero", 32'(cfg_rdata_o), 32'hFFF7);
        step(0, 0, 0, 1, 17'h0009);
        @(negedge clk);
        check("R6 abs readback after write", 32'(abs_rdata_o), 32'h9);

        // R1 reset during a running countdown
        step(1, 0, 0, 0, 17'h0);
        @(negedge clk);
        step(0, 1, 0, 0, 17'h0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 irq after mid-run reset", 32'(irq_o), 0);
        check("R1 cfg after mid-run reset", 32'(cfg_rdata_o), 0);
        begin
            int seen = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                step(0, 1, 0, 0, 17'h0);
                if (irq_o || flush_o) seen++;
            end
            check("R1 no pulse from ticks after reset", 32'(seen), 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule